// File: doc/BRIEF.md
# Row and Column Bypassing Array Multiplier

This block multiplies two unsigned operands of equal width with a carry-save array of gated adder cells. It returns a double-width product one clock cycle after a valid strobe. Every cell looks at two inputs: its own partial-product bit and the carry that arrives from the row above. When both are zero, the cell performs no addition. It forwards its incoming partial sum unchanged, emits a zero carry, and forces its adder inputs low so that the adder does not toggle.

A multiplier bit of zero clears every partial-product bit in its row, and a multiplicand bit of zero clears them down a whole column. Sparse operands therefore leave large parts of the array idle. The bottom row of the array leaves one vector of sums and one of carries, and a ripple adder merges them into the upper half of the product. The result is captured in an output register only when the input strobe is high, so the last product stays on the output between operations.

Top module: `bypass_array_mult`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid` is 0 and `prod` is 0 after that edge.
- R2: When `in_valid` is high at an edge, `out_valid` is 1 after that edge and `prod` equals `a_op * b_op` (unsigned, 2×WIDTH bits). When `in_valid` is low, `out_valid` is 0 after the edge.
- R3: When `in_valid` is low, `prod` keeps its previous value whatever `a_op` and `b_op` do.
- R4: An operand of zero gives a product of zero, because every row or every column of the array is bypassed.
- R5: A multiplier `b_op` with a single bit k set, so that only row k adds, gives `a_op` shifted left by k.
- R6: A multiplicand `a_op` with a single bit k set, so that only one column of partial products is non-zero, gives `b_op` shifted left by k.
- R7: All-ones operands give (2^WIDTH − 1)^2. In this case no cell is bypassed and every carry path is exercised.
- R8: Operations issued on consecutive cycles each produce their own correct product on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands are valid this cycle |
| a_op | input | WIDTH | Multiplicand, unsigned |
| b_op | input | WIDTH | Multiplier, unsigned |
| out_valid | output | 1 | `prod` holds a new result |
| prod | output | 2*WIDTH | Registered product |

## Verification
The bench builds two copies of the block. The first uses WIDTH = 12, the target size, and runs it with random operands, back-to-back streams and directed single-bit, zero and all-ones patterns. The second uses WIDTH = 4, which is small enough to apply all 256 operand pairs. That exhaustive run reaches every combination of bypassed and active cells, including the ones where a carry alone wakes a cell whose partial-product bit is zero.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

    // sum and carry pair produced by one adder cell
    typedef struct packed {
        logic cry;
        logic sum;
    } sc_t;

    function automatic sc_t full_add(input logic x, input logic y, input logic z);
        sc_t r;
        r.sum = x ^ y ^ z;
        r.cry = (x & y) | (x & z) | (y & z);
        return r;
    endfunction

    // a cell only has work to do when its own term or its incoming carry is set
    function automatic logic cell_fires(input logic pp, input logic cry);
        return pp | cry;
    endfunction

endpackage

// File: rtl/bpm_cell.sv
module bpm_cell
    import bpm_pkg::*;
(
    input  logic pp_i,
    input  logic sum_i,
    input  logic cry_i,
    output logic sum_o,
    output logic cry_o
);
    logic fire;
    logic gx, gy, gz;
    sc_t  res;

    assign fire = cell_fires(pp_i, cry_i);

    // operand gating keeps the adder quiet while the cell is skipped
    assign gx = pp_i  & fire;
    assign gy = sum_i & fire;
    assign gz = cry_i & fire;

    assign res = full_add(gx, gy, gz);

    always_comb begin
        if (fire) begin
            sum_o = res.sum;
            cry_o = res.cry;
        end else begin
            sum_o = sum_i;
            cry_o = 1'b0;
        end
    end
endmodule

// File: rtl/bpm_array.sv
module bpm_array #(
    parameter int W = 12
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] low_o,
    output logic [W-1:0] hsum_o,
    output logic [W-1:0] hcry_o
);
    logic [W-1:0] srow [W];
    logic [W-1:0] crow [W];

    // first row is a plain AND row with no carries
    assign srow[0] = a_i & {W{b_i[0]}};
    assign crow[0] = '0;

    for (genvar j = 1; j < W; j++) begin : g_row
        for (genvar i = 0; i < W; i++) begin : g_col
            logic s_in;
            if (i == W - 1) begin : g_edge
                assign s_in = 1'b0;
            end else begin : g_inner
                assign s_in = srow[j-1][i+1];
            end
            bpm_cell u_cell (
                .pp_i  (a_i[i] & b_i[j]),
                .sum_i (s_in),
                .cry_i (crow[j-1][i]),
                .sum_o (srow[j][i]),
                .cry_o (crow[j][i])
            );
        end
    end

    for (genvar j = 0; j < W; j++) begin : g_low
        assign low_o[j] = srow[j][0];
    end

    assign hsum_o = {1'b0, srow[W-1][W-1:1]};
    assign hcry_o = crow[W-1];
endmodule

// File: rtl/bpm_ripple.sv
module bpm_ripple
    import bpm_pkg::*;
#(
    parameter int W = 12
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] sum_o
);
    logic [W-1:0] chain;

    assign chain[0] = 1'b0;

    for (genvar k = 0; k < W; k++) begin : g_bit
        if (k < W - 1) begin : g_mid
            sc_t r;
            assign r          = full_add(x_i[k], y_i[k], chain[k]);
            assign sum_o[k]   = r.sum;
            assign chain[k+1] = r.cry;
        end else begin : g_top
            // the product fits in 2W bits, so no carry leaves the top stage
            assign sum_o[k] = x_i[k] ^ y_i[k] ^ chain[k];
        end
    end
endmodule

// File: rtl/bypass_array_mult.sv
module bypass_array_mult #(
    parameter int WIDTH = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [WIDTH-1:0]   a_op,
    input  logic [WIDTH-1:0]   b_op,
    output logic               out_valid,
    output logic [2*WIDTH-1:0] prod
);
    localparam int PW = 2 * WIDTH;

    logic [WIDTH-1:0] low_bits;
    logic [WIDTH-1:0] hsum;
    logic [WIDTH-1:0] hcry;
    logic [WIDTH-1:0] high_bits;
    logic [PW-1:0]    prod_d;

    bpm_array #(.W(WIDTH)) u_array (
        .a_i    (a_op),
        .b_i    (b_op),
        .low_o  (low_bits),
        .hsum_o (hsum),
        .hcry_o (hcry)
    );

    bpm_ripple #(.W(WIDTH)) u_merge (
        .x_i   (hsum),
        .y_i   (hcry),
        .sum_o (high_bits)
    );

    assign prod_d = {high_bits, low_bits};

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            prod      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                prod <= prod_d;
            end
        end
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && prod == '0));

    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    vld_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R2
    prod_value_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> prod == (PW'($past(a_op)) * PW'($past(b_op))));

    // R3
    prod_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(prod));

    // R4
    zero_op_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (a_op == '0 || b_op == '0)) |=> prod == '0);
endmodule

// File: tb/sim_bypass_array_mult.sv
module sim_bypass_array_mult;
    localparam int W  = 12;
    localparam int WS = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;

    logic            v0 = 1'b0;
    logic [W-1:0]    a0 = '0, b0 = '0;
    logic            ov0;
    logic [2*W-1:0]  p0;

    logic            v1 = 1'b0;
    logic [WS-1:0]   a1 = '0, b1 = '0;
    logic            ov1;
    logic [2*WS-1:0] p1;

    int nrun  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    bypass_array_mult #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .in_valid(v0), .a_op(a0), .b_op(b0),
        .out_valid(ov0), .prod(p0)
    );

    bypass_array_mult #(.WIDTH(WS)) u1 (
        .clk(clk), .rst(rst), .in_valid(v1), .a_op(a1), .b_op(b1),
        .out_valid(ov1), .prod(p1)
    );

    function automatic logic [63:0] ref_mul(input logic [31:0] x, input logic [31:0] y);
        logic [63:0] acc = '0;
        for (int k = 0; k < 32; k++) begin
            if (y[k]) acc = acc + (64'(x) << k);
        end
        return acc;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        nrun++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic op12(input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
        logic [63:0] e;
        e = ref_mul(32'(x), 32'(y));
        @(negedge clk);
        a0 = x; b0 = y; v0 = 1'b1;
        @(negedge clk);
        v0 = 1'b0;
        check(ov0 == 1'b1, "R2 valid", 64'(ov0), 64'd1);
        check(64'(p0) == e, tag, 64'(p0), e);
    endtask

    initial begin
        logic [W-1:0] ra, rb, pa, pb;
        logic [63:0]  held;
        void'($urandom(32'd4821));

        repeat (3) @(negedge clk);
        // R1: still in reset
        check(ov0 == 1'b0 && p0 == '0, "R1", 64'(p0), 64'd0);
        check(ov1 == 1'b0 && p1 == '0, "R1", 64'(p1), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(ov0 == 1'b0, "R2 idle valid", 64'(ov0), 64'd0);

        // R4: zero operands
        op12('0, W'($urandom), "R4");
        op12(W'($urandom) | W'(1), '0, "R4");
        op12('0, '0, "R4");

        // R7: all ones
        op12('1, '1, "R7");

        // R5: single-bit multiplier, one active row
        for (int k = 0; k < W; k++) begin
            ra = W'($urandom);
            op12(ra, W'(1) << k, "R5");
        end

        // R6: single-bit multiplicand, one active column
        for (int k = 0; k < W; k++) begin
            rb = W'($urandom);
            op12(W'(1) << k, rb, "R6");
        end

        // R3: operands move while the strobe is low
        op12(12'hA5C, 12'h3B7, "R2");
        held = ref_mul(32'h0A5C, 32'h03B7);
        for (int k = 0; k < 4; k++) begin
            a0 = W'($urandom);
            b0 = W'($urandom);
            @(negedge clk);
            check(64'(p0) == held, "R3", 64'(p0), held);
            check(ov0 == 1'b0, "R3 valid", 64'(ov0), 64'd0);
        end

        // R2: random single operations
        for (int k = 0; k < 1500; k++) begin
            op12(W'($urandom), W'($urandom), "R2");
        end

        // R8: back-to-back stream
        pa = '0; pb = '0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (k > 0) begin
                check(ov0 == 1'b1, "R8 valid", 64'(ov0), 64'd1);
                check(64'(p0) == ref_mul(32'(pa), 32'(pb)), "R8",
                      64'(p0), ref_mul(32'(pa), 32'(pb)));
            end
            pa = W'($urandom);
            pb = (k % 5 == 0) ? '0 : W'($urandom);
            a0 = pa; b0 = pb; v0 = 1'b1;
        end
        @(negedge clk);
        v0 = 1'b0;
        check(64'(p0) == ref_mul(32'(pa), 32'(pb)), "R8",
              64'(p0), ref_mul(32'(pa), 32'(pb)));

        // R2 and R4 on the small array: every operand pair
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                @(negedge clk);
                a1 = WS'(x); b1 = WS'(y); v1 = 1'b1;
                @(negedge clk);
                v1 = 1'b0;
                check(64'(p1) == ref_mul(32'(x), 32'(y)),
                      (x == 0 || y == 0) ? "R4 small" : "R2 small",
                      64'(p1), ref_mul(32'(x), 32'(y)));
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", nrun, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nrun++;
            nfail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", nrun, nfail);
            $finish;
        end
    end
endmodule